// File: doc/BRIEF.md
# Programmable Modulus Phase Accumulator

This block generates the phase sequence for a direct digital synthesizer whose average phase step is a compound tuning word: an integer part X plus an exact fraction A/B. A 32-bit power-of-two accumulator adds X on every sample clock. Beside it, a residue accumulator adds A and wraps modulo B. On each clock where that residue wraps, the primary adder's carry-in is raised for that same clock. Over any run of B samples the primary phase therefore advances by exactly B·X + A. This makes any rational ratio fO/fS = (X + A/B)/2^32 reachable with zero frequency error. A plain accumulator can only reach ratios of the form M/2^32.

A single-cycle load strobe captures X, A and B and the fraction enable, and clears both accumulators on the same edge. A small controller holds the operating mode in three named states:

- ST_IDLE is entered on reset. The phase stays at zero.
- ST_INT is integer-only operation, with the residue frozen to save power.
- ST_FRAC is fractional operation.

The transitions are as follows:

- IDLE_TO_INT, INT_TO_INT and FRAC_TO_INT happen on a load whose word is not fractional. A word is not fractional when the enable is low, A is zero or B is zero.
- IDLE_TO_FRAC, INT_TO_FRAC and FRAC_TO_FRAC happen on a load with the enable high and both A and B nonzero.
- Without a load, the state holds.

The phase handed to the amplitude stage is the top PHASE_W bits of the primary accumulator. This keeps the power-of-two angle mapping intact.

Top module: `pmod_phase_acc`

## Requirements
- R1: After reset the block is in ST_IDLE and phase_o is 0. It stays 0 on every clock until the first load, whatever the other inputs do.
- R2: On the clock edge where load_i is 1, both accumulators are cleared. phase_o reads 0 immediately after that edge.
- R3: In ST_INT (entered by a load with mod_en_i=0, frac_num_i=0 or frac_den_i=0), n clocks after the load the primary accumulator holds n·X mod 2^32. The residue accumulator does not change.
- R4: In ST_FRAC (entered by a load with mod_en_i=1, 0 < A < B), n clocks after the load the primary accumulator holds floor(n·(X·B + A)/B) mod 2^32.
- R5: In ST_FRAC, over any B consecutive clocks the primary accumulator advances by exactly B·X + A mod 2^32. For example, X=429496729, A=3, B=5 gives 5·X+3 = 2^31 after five clocks, which is exactly fS/10.
- R6: Each clock the primary accumulator advances by X in ST_INT, and by X or X+1 in ST_FRAC.
- R7: Changes on mod_en_i, int_word_i, frac_num_i and frac_den_i without a load have no effect on the phase sequence.
- R8: phase_o equals bits [31:32-PHASE_W] of the primary accumulator.
- R9: A load while running restarts the sequence from zero with the newly captured word and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture tuning word and clear accumulators |
| mod_en_i | input | 1 | Request fractional operation at the next load |
| int_word_i | input | 32 | Integer step X |
| frac_num_i | input | 32 | Fraction numerator A |
| frac_den_i | input | 32 | Fraction denominator B |
| phase_o | output | PHASE_W | Truncated phase, top bits of the primary accumulator |

## Verification
The checker relies on one condition for fractional operation: the captured numerator is strictly below the denominator. Only under that condition does the residue stay below B and the per-clock step stay within X and X+1. The stimulus respects this in two ways. Every fractional load draws A as a random value taken modulo a nonzero B, and the directed corners include A = B−1 with B near 2^32. Between loads the data pins are scrambled freely, since they must be ignored there. The load strobe is held for a single cycle.

// File: rtl/pmod_pkg.sv
package pmod_pkg;

    localparam int ACC_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INT  = 2'd1,
        ST_FRAC = 2'd2
    } pmod_mode_e;

    typedef struct packed {
        logic [ACC_W-1:0] step;
        logic [ACC_W-1:0] num;
        logic [ACC_W-1:0] den;
    } pmod_word_t;

endpackage

// File: rtl/pmod_ctrl.sv
module pmod_ctrl
    import pmod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             mod_en_i,
    input  logic [ACC_W-1:0] step_i,
    input  logic [ACC_W-1:0] num_i,
    input  logic [ACC_W-1:0] den_i,
    output pmod_mode_e       mode_o,
    output pmod_word_t       word_o,
    output logic             clear_o,
    output logic             run_o,
    output logic             frac_o
);

    pmod_mode_e state_q;
    pmod_mode_e state_d;
    pmod_word_t word_q;
    logic       frac_req;

    assign frac_req = mod_en_i && (num_i != '0) && (den_i != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q.step <= step_i;
            word_q.num  <= num_i;
            word_q.den  <= den_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) state_d = frac_req ? ST_FRAC : ST_INT;
            end
            ST_INT: begin
                if (load_i) state_d = frac_req ? ST_FRAC : ST_INT;
            end
            ST_FRAC: begin
                if (load_i) state_d = frac_req ? ST_FRAC : ST_INT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        clear_o = load_i;
        run_o   = 1'b0;
        frac_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run_o  = 1'b0;
                frac_o = 1'b0;
            end
            ST_INT: begin
                run_o  = !load_i;
                frac_o = 1'b0;
            end
            ST_FRAC: begin
                run_o  = !load_i;
                frac_o = !load_i;
            end
            default: begin
                run_o  = 1'b0;
                frac_o = 1'b0;
            end
        endcase
    end

    assign mode_o = state_q;
    assign word_o = word_q;

endmodule

// File: rtl/pmod_residue.sv
module pmod_residue #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         active_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         carry_o,
    output logic [W-1:0] resid_o
);

    localparam int SUM_W = W + 1;

    logic [W-1:0]     resid_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] sum_less;
    logic             wrap;
    logic [W-1:0]     resid_d;

    assign sum      = {1'b0, resid_q} + {1'b0, num_i};
    assign sum_less = sum - {1'b0, den_i};
    assign wrap     = (sum >= {1'b0, den_i});
    assign resid_d  = wrap ? sum_less[W-1:0] : sum[W-1:0];
    assign carry_o  = active_i && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resid_q <= '0;
        end else if (clear_i) begin
            resid_q <= '0;
        end else if (active_i) begin
            resid_q <= resid_d;
        end
    end

    assign resid_o = resid_q;

endmodule

// File: rtl/pmod_primary.sv
module pmod_primary #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         run_i,
    input  logic [W-1:0] step_i,
    input  logic         carry_i,
    output logic [W-1:0] acc_o
);

    logic [W-1:0] acc_q;
    logic [W-1:0] acc_d;

    assign acc_d = acc_q + step_i + {{(W-1){1'b0}}, carry_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (run_i) begin
            acc_q <= acc_d;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/pmod_phase_acc.sv
module pmod_phase_acc
    import pmod_pkg::*;
#(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               mod_en_i,
    input  logic [ACC_W-1:0]   int_word_i,
    input  logic [ACC_W-1:0]   frac_num_i,
    input  logic [ACC_W-1:0]   frac_den_i,
    output logic [PHASE_W-1:0] phase_o
);

    localparam int DROP_W = ACC_W - PHASE_W;

    pmod_mode_e       mode_w;
    pmod_word_t       word_w;
    logic             clear_w;
    logic             run_w;
    logic             frac_w;
    logic             carry_w;
    logic [ACC_W-1:0] resid_w;
    logic [ACC_W-1:0] acc_w;

    pmod_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .mod_en_i (mod_en_i),
        .step_i   (int_word_i),
        .num_i    (frac_num_i),
        .den_i    (frac_den_i),
        .mode_o   (mode_w),
        .word_o   (word_w),
        .clear_o  (clear_w),
        .run_o    (run_w),
        .frac_o   (frac_w)
    );

    pmod_residue #(.W(ACC_W)) u_residue (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_w),
        .active_i (frac_w),
        .num_i    (word_w.num),
        .den_i    (word_w.den),
        .carry_o  (carry_w),
        .resid_o  (resid_w)
    );

    pmod_primary #(.W(ACC_W)) u_primary (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_w),
        .run_i    (run_w),
        .step_i   (word_w.step),
        .carry_i  (carry_w),
        .acc_o    (acc_w)
    );

    generate
        if (DROP_W == 0) begin : g_full
            assign phase_o = acc_w;
        end else begin : g_trunc
            assign phase_o = acc_w[ACC_W-1:DROP_W];
        end
    endgenerate

endmodule

// File: rtl/pmod_phase_acc_chk.sv
module pmod_phase_acc_chk
    import pmod_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input pmod_mode_e       mode_w,
    input pmod_word_t       word_w,
    input logic [ACC_W-1:0] resid_w,
    input logic [ACC_W-1:0] acc_w
);

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == ST_IDLE) |-> (acc_w == '0)); // R1

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (acc_w == '0 && resid_w == '0)); // R2

    AST_INT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == ST_INT && !load_i) |=> (acc_w == $past(acc_w) + $past(word_w.step))); // R3

    AST_RESID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w != ST_FRAC && !load_i) |=> $stable(resid_w)); // R3

    AST_RESID_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == ST_FRAC) |-> (resid_w < word_w.den)); // R4

    AST_FRAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == ST_FRAC && !load_i) |=>
            ((acc_w - $past(acc_w) - $past(word_w.step)) <= 32'd1)); // R6

endmodule

bind pmod_phase_acc pmod_phase_acc_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .mode_w  (mode_w),
    .word_w  (word_w),
    .resid_w (resid_w),
    .acc_w   (acc_w)
);

// File: tb/test_pmod_phase_acc.sv
module test_pmod_phase_acc;

    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          mod_en_i = 1'b0;
    logic [31:0]   int_word_i = '0;
    logic [31:0]   frac_num_i = '0;
    logic [31:0]   frac_den_i = '0;
    logic [PW-1:0] phase_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] hist [0:63];

    pmod_phase_acc #(.PHASE_W(PW)) i_pmod_phase_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .mod_en_i   (mod_en_i),
        .int_word_i (int_word_i),
        .frac_num_i (frac_num_i),
        .frac_den_i (frac_den_i),
        .phase_o    (phase_o)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] ref_phase(int unsigned n, logic [31:0] x,
                                              logic [31:0] a, logic [31:0] b, bit frac);
        logic [127:0] num;
        if (!frac) return 32'(n * x);
        num = 128'(n) * (128'(x) * 128'(b) + 128'(a));
        return 32'(num / 128'(b));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scramble();
        mod_en_i   = 1'($urandom);
        int_word_i = $urandom;
        frac_num_i = $urandom;
        frac_den_i = $urandom;
    endtask

    // R2 R3 R4 R5 R6 R7 R9: load a word, then follow the sequence
    task automatic run_cfg(logic [31:0] x, logic [31:0] a, logic [31:0] b, bit en, int steps);
        bit frac;
        frac = en && (a != 0) && (b != 0);
        @(negedge clk);
        load_i = 1'b1; mod_en_i = en;
        int_word_i = x; frac_num_i = a; frac_den_i = b;
        @(negedge clk);
        load_i = 1'b0;
        check("R2", phase_o, 32'd0);
        hist[0] = phase_o;
        scramble(); // R7: pins ignored without a load
        for (int n = 1; n <= steps; n++) begin
            @(negedge clk);
            hist[n] = phase_o;
            check(frac ? "R4" : "R3", phase_o, ref_phase(n, x, a, b, frac));
            // R6: single-step size
            if (frac) begin
                checks++;
                if ((hist[n] - hist[n-1] - x) > 32'd1) begin
                    errors++;
                    $display("FAIL R6 actual=%h expected=%h or +1", hist[n] - hist[n-1], x);
                end
            end else begin
                check("R6", hist[n] - hist[n-1], x);
            end
            // R5: window of B clocks
            if (frac && b <= 32'(n) && n > int'(b))
                check("R5", hist[n] - hist[n-int'(b)], 32'(b * x + a));
            scramble();
        end
        if (frac && b <= 32'(steps))
            check("R5", hist[int'(b)], 32'(b * x + a));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: phase stays 0 before any load
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R1", phase_o, 32'd0);
            scramble();
        end
        // directed: exact fS/10, R5 gives 2^31 after five clocks
        run_cfg(32'd429496729, 32'd3, 32'd5, 1'b1, 40);
        check("R5", hist[5], 32'h8000_0000);
        // R3: enable low, A=0, B=0 all mean integer stepping
        run_cfg(32'd429496729, 32'd3, 32'd5, 1'b0, 20);
        run_cfg(32'h1234_5679, 32'd0, 32'd7, 1'b1, 20);
        run_cfg(32'h0F0F_0F0F, 32'd9, 32'd0, 1'b1, 20);
        // R4: large denominator, numerator one below it
        run_cfg(32'hFFFF_FFF0, 32'hFFFF_FFFD, 32'hFFFF_FFFE, 1'b1, 30);
        run_cfg(32'd0, 32'd1, 32'd3, 1'b1, 30);
        // R9: random reloads mid-run; each load restarts from zero
        for (int k = 0; k < 25; k++) begin
            logic [31:0] b, a;
            b = (k % 2 == 0) ? ($urandom % 60 + 1) : ($urandom | 32'd1);
            a = $urandom % b;
            run_cfg($urandom, a, b, 1'($urandom % 4 != 0), 35 + k % 20);
        end
        // R8: with full width, phase equals accumulator; top byte of fS/10 word
        run_cfg(32'd429496729, 32'd3, 32'd5, 1'b1, 10);
        check("R8", {24'd0, phase_o[PW-1 -: 8]}, {24'd0, hist[10][31:24]});
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule